// File: doc/BRIEF.md
# Shifter Operand Generation Unit

This block prepares the second operand of a 32-bit datapath and the carry that the shift produces. The operand comes from one of four sources. It can be a register value shifted by a 5-bit constant. It can be a register value shifted by an amount held in the low byte of a second register. It can be an 8-bit constant rotated right by an even distance. It can be an 8-bit constant scaled by four. For each shift, the carry-out is the last bit that left the word. When nothing moves, the incoming carry goes through unchanged.

Requests arrive on a valid/ready input and leave through a single registered valid/ready output stage. A request is taken on a rising clock edge when `in_valid` and `in_ready` are both high. Its result shows on `out_operand`/`out_carry` from that edge on, with `out_valid` high. The result is handed over on the first edge where `out_ready` is high. `in_ready` is high whenever the output stage is empty or is being drained in that cycle, so a stalled consumer stalls the producer without losing data. The field encodings are: `in_mode` 00 shift by constant, 01 shift by register, 10 rotated constant, 11 scaled constant. `in_kind` 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right.

Top module: `shop_unit`

## Requirements
- R1: Mode 00 with kind 00 shifts `in_rm` left by `in_imm5` (0 to 31). The carry is the last bit shifted out. A distance of 0 returns `in_rm` and `in_carry` unchanged.
- R2: Mode 00 with kind 01 or 10 shifts right by `in_imm5`, and an encoded 0 means a distance of 32. Right logical by 32 gives 0 with carry `in_rm[31]`. Right arithmetic by 32 gives every bit equal to `in_rm[31]` with carry `in_rm[31]`.
- R3: Mode 00 with kind 11 rotates right by `in_imm5` (1 to 31), and the carry equals result bit 31. An encoded 0 instead gives a one-place rotate through the carry: the result is `{in_carry, in_rm[31:1]}` and the carry is `in_rm[0]`.
- R4: Mode 01 takes its distance from `in_rs[7:0]` only, so bits 31:8 have no effect. A distance of 0 returns `in_rm` and `in_carry` unchanged for every kind.
- R5: Mode 01 with left or right logical by exactly 32 gives 0, with carry `in_rm[0]` for left and `in_rm[31]` for right. By more than 32 it gives 0 with carry 0.
- R6: Mode 01 right arithmetic by 32 or more gives every bit equal to `in_rm[31]`, with carry `in_rm[31]`.
- R7: Mode 01 rotate uses the distance modulo 32, and the carry equals result bit 31. A nonzero multiple of 32 returns `in_rm` with carry `in_rm[31]`.
- R8: Mode 10 rotates the zero-extended `in_imm8` right by twice `in_rot4`. The carry is `in_carry` when `in_rot4` is 0 and result bit 31 otherwise.
- R9: Mode 11 gives `{22'b0, in_imm8, 2'b00}` and passes `in_carry` through.
- R10: After reset `out_valid` is low. `in_ready` equals `!out_valid || out_ready`. An accepted request sets `out_valid` on the next edge. While `out_valid` is high and `out_ready` is low, the outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_mode | input | 2 | Operand source select |
| in_kind | input | 2 | Shift kind for modes 00 and 01 |
| in_imm5 | input | 5 | Constant shift distance |
| in_rs | input | 32 | Register holding the shift distance |
| in_rm | input | 32 | Register value to shift |
| in_imm8 | input | 8 | 8-bit constant |
| in_rot4 | input | 4 | Half of the rotate distance for mode 10 |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result this cycle |
| out_operand | output | 32 | Generated operand |
| out_carry | output | 1 | Shifter carry-out |

## Verification
The assertions assume that all request fields stay stable and defined while `in_valid` is high and the request has not yet been taken. They also assume that `out_ready` is a plain level with no dependence on `out_valid`. The bench drives every field and `in_valid` only just after a falling edge and holds them until it sees `in_ready` high. It toggles `out_ready` on its own schedule, so the assumption of stable held requests is met while stalls still happen often. Random distances are drawn with a bias toward 0, 1, 31, 32, 33 and values above 255 in the upper bits of `in_rs`, so the boundary cases are well covered.

// File: rtl/shop_pkg.sv
package shop_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    OPM_IMM_SHIFT  = 2'b00,
    OPM_REG_SHIFT  = 2'b01,
    OPM_ROT_IMM    = 2'b10,
    OPM_SCALED_IMM = 2'b11
  } op_mode_e;

  localparam int unsigned AMT_W = 8;

  typedef struct packed {
    shift_kind_e      kind;
    logic [AMT_W-1:0] amt;
    logic             rrx;
  } shift_req_t;
endpackage

// File: rtl/sh_amount_decode.sv
module sh_amount_decode
  import shop_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  op_mode_e         mode,
  input  shift_kind_e      kind,
  input  logic [4:0]       imm5,
  input  logic [AMT_W-1:0] rs_low,
  output shift_req_t       req
);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(W);

  always_comb begin
    req.kind = kind;
    req.rrx  = 1'b0;
    req.amt  = rs_low;
    if (mode == OPM_IMM_SHIFT) begin
      req.amt = AMT_W'(imm5);
      if (imm5 == 5'd0) begin
        unique case (kind)
          SH_LSR, SH_ASR: req.amt = FULL_AMT;
          SH_ROR:         req.rrx = 1'b1;
          default:        req.amt = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sh_barrel.sv
module sh_barrel
  import shop_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  shift_req_t   req,
  input  logic [W-1:0] rm,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int unsigned SH_W = $clog2(W);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(W);
  localparam logic [AMT_W-1:0] PAST_AMT = AMT_W'(W + 1);

  logic [AMT_W-1:0]        amt_log;
  logic [AMT_W-1:0]        amt_ari;
  logic [SH_W-1:0]         amt_rot;
  logic [2*W-1:0]          lsl_t;
  logic [2*W-1:0]          lsr_t;
  logic signed [2*W-1:0]   asr_src;
  logic signed [2*W-1:0]   asr_t;
  logic [2*W-1:0]          ror_t;

  always_comb begin
    amt_log = (req.amt > FULL_AMT) ? PAST_AMT : req.amt;
    amt_ari = (req.amt > FULL_AMT) ? FULL_AMT : req.amt;
    amt_rot = req.amt[SH_W-1:0];
    lsl_t   = {{W{1'b0}}, rm} << amt_log;
    lsr_t   = {rm, {W{1'b0}}} >> amt_log;
    asr_src = {rm, {W{1'b0}}};
    asr_t   = asr_src >>> amt_ari;
    ror_t   = {rm, rm} >> amt_rot;
  end

  always_comb begin
    res  = rm;
    cout = cin;
    if (req.rrx) begin
      res  = {cin, rm[W-1:1]};
      cout = rm[0];
    end else if (req.amt != '0) begin
      unique case (req.kind)
        SH_LSL: begin res = lsl_t[W-1:0];   cout = lsl_t[W];     end
        SH_LSR: begin res = lsr_t[2*W-1:W]; cout = lsr_t[W-1];   end
        SH_ASR: begin res = asr_t[2*W-1:W]; cout = asr_t[W-1];   end
        default: begin res = ror_t[W-1:0];  cout = ror_t[W-1];   end
      endcase
    end
  end
endmodule

// File: rtl/sh_imm_gen.sv
module sh_imm_gen
  import shop_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned IMM_W = 8,
  parameter int unsigned ROT_W = 4
) (
  input  logic             scaled,
  input  logic [IMM_W-1:0] imm,
  input  logic [ROT_W-1:0] rot,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout
);
  logic [W-1:0]   base;
  logic [2*W-1:0] rot_t;

  always_comb begin
    base  = {{(W-IMM_W){1'b0}}, imm};
    rot_t = {base, base} >> {rot, 1'b0};
    if (scaled) begin
      res  = {{(W-IMM_W-2){1'b0}}, imm, 2'b00};
      cout = cin;
    end else begin
      res  = rot_t[W-1:0];
      cout = (rot == '0) ? cin : rot_t[W-1];
    end
  end
endmodule

// File: rtl/shop_unit.sv
module shop_unit
  import shop_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned IMM_W = 8,
  parameter int unsigned ROT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_mode,
  input  logic [1:0]       in_kind,
  input  logic [4:0]       in_imm5,
  input  logic [W-1:0]     in_rs,
  input  logic [W-1:0]     in_rm,
  input  logic [IMM_W-1:0] in_imm8,
  input  logic [ROT_W-1:0] in_rot4,
  input  logic             in_carry,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_operand,
  output logic             out_carry
);
  op_mode_e     mode;
  shift_req_t   req;
  logic [W-1:0] sh_res;
  logic         sh_c;
  logic [W-1:0] im_res;
  logic         im_c;
  logic         take;

  assign mode     = op_mode_e'(in_mode);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  sh_amount_decode #(.W(W)) u_dec (
    .mode   (mode),
    .kind   (shift_kind_e'(in_kind)),
    .imm5   (in_imm5),
    .rs_low (in_rs[AMT_W-1:0]),
    .req    (req)
  );

  sh_barrel #(.W(W)) u_bar (
    .req  (req),
    .rm   (in_rm),
    .cin  (in_carry),
    .res  (sh_res),
    .cout (sh_c)
  );

  sh_imm_gen #(.W(W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .scaled (mode == OPM_SCALED_IMM),
    .imm    (in_imm8),
    .rot    (in_rot4),
    .cin    (in_carry),
    .res    (im_res),
    .cout   (im_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_operand <= '0;
      out_carry   <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_operand <= mode[1] ? im_res : sh_res;
        out_carry   <= mode[1] ? im_c : sh_c;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

  // R10: a stalled result holds its value
  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_operand) && $stable(out_carry));

  // R10: an accepted request appears on the next edge
  a_r10_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  a_r9_scaled_imm: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode == 2'b11 |=>
      out_operand == {{(W-IMM_W-2){1'b0}}, $past(in_imm8), 2'b00} && out_carry == $past(in_carry));

  a_r4_zero_passes: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode == 2'b01 && in_rs[AMT_W-1:0] == '0 |=>
      out_operand == $past(in_rm) && out_carry == $past(in_carry));

  a_r3_rrx: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode == 2'b00 && in_kind == 2'b11 && in_imm5 == 5'd0 |=>
      out_operand[W-1] == $past(in_carry) && out_carry == $past(in_rm[0]));

  a_r5_lsl_far: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode == 2'b01 && in_kind == 2'b00 && in_rs[AMT_W-1:0] > AMT_W'(W) |=>
      out_operand == '0 && !out_carry);
endmodule

// File: tb/shop_unit_tb.sv
module shop_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = '0;
  logic [1:0]  in_kind = '0;
  logic [4:0]  in_imm5 = '0;
  logic [31:0] in_rs = '0;
  logic [31:0] in_rm = '0;
  logic [7:0]  in_imm8 = '0;
  logic [3:0]  in_rot4 = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_operand;
  logic        out_carry;

  int n_cmp = 0;
  int n_bad = 0;
  bit stall_on = 1'b0;
  bit done = 1'b0;

  logic [32:0] exp_q[$];
  int          tag_q[$];

  always #2.5 clk = ~clk;

  shop_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_kind(in_kind), .in_imm5(in_imm5), .in_rs(in_rs),
    .in_rm(in_rm), .in_imm8(in_imm8), .in_rot4(in_rot4), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready), .out_operand(out_operand),
    .out_carry(out_carry)
  );

  function automatic logic [32:0] model(input logic [1:0] md, input logic [1:0] kd,
      input logic [4:0] i5, input logic [31:0] rs, input logic [31:0] rm,
      input logic [7:0] i8, input logic [3:0] r4, input logic ci, output int tag);
    logic [31:0] v;
    logic        c;
    int          n;
    v = rm; c = ci; n = 0; tag = 0;
    if (md == 2'b10) begin
      tag = 8;
      v = {24'b0, i8};
      for (int i = 0; i < 2 * r4; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
      return {c, v};
    end
    if (md == 2'b11) begin
      tag = 9;
      return {ci, 22'b0, i8, 2'b00};
    end
    if (md == 2'b00) begin
      if (kd == 2'b11 && i5 == 0) begin
        tag = 3;
        return {rm[0], ci, rm[31:1]};
      end
      n = int'(i5);
      if ((kd == 2'b01 || kd == 2'b10) && n == 0) n = 32;
      tag = (kd == 2'b00) ? 1 : (kd == 2'b11) ? 3 : 2;
    end else begin
      n = int'(rs[7:0]);
      if (n == 0) tag = 4;
      else if (kd == 2'b10 && n >= 32) tag = 6;
      else if (kd == 2'b11) tag = 7;
      else if (n >= 32) tag = 5;
      else tag = 4;
    end
    for (int i = 0; i < n; i++) begin
      case (kd)
        2'b00: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'b01: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  // consumer back-pressure
  always @(negedge clk) begin
    if (stall_on) out_ready <= ($urandom % 3) != 0;
    else          out_ready <= 1'b1;
  end

  // cycle-by-cycle comparison against the model queue
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      n_cmp++;
      if (in_ready !== (!out_valid || out_ready)) begin
        n_bad++;
        $display("FAIL R10 in_ready act=%b exp=%b", in_ready, !out_valid || out_ready);
      end
      if (out_valid) begin
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R10 out_valid act=1 exp=0 (nothing pending)");
        end else if ({out_carry, out_operand} !== exp_q[0]) begin
          n_bad++;
          $display("FAIL R%0d act=%b_%h exp=%b_%h", tag_q[0], out_carry, out_operand,
                   exp_q[0][32], exp_q[0][31:0]);
        end
        if (out_ready && exp_q.size() != 0) begin
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end else if (exp_q.size() != 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10 out_valid act=0 exp=1");
      end
      if (in_valid && in_ready) begin
        int t;
        logic [32:0] e;
        e = model(in_mode, in_kind, in_imm5, in_rs, in_rm, in_imm8, in_rot4, in_carry, t);
        exp_q.push_back(e);
        tag_q.push_back(t);
      end
    end
  end

  task automatic send(input logic [1:0] md, input logic [1:0] kd, input logic [4:0] i5,
      input logic [31:0] rs, input logic [31:0] rm, input logic [7:0] i8,
      input logic [3:0] r4, input logic ci);
    @(negedge clk);
    in_mode = md; in_kind = kd; in_imm5 = i5; in_rs = rs; in_rm = rm;
    in_imm8 = i8; in_rot4 = r4; in_carry = ci; in_valid = 1'b1;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
  endtask

  function automatic logic [31:0] pick_rs();
    case ($urandom % 8)
      0: return {$urandom} & 32'hFFFF_FF00;
      1: return ({$urandom} & 32'hFFFF_FF00) | 32'd1;
      2: return ({$urandom} & 32'hFFFF_FF00) | 32'd31;
      3: return ({$urandom} & 32'hFFFF_FF00) | 32'd32;
      4: return ({$urandom} & 32'hFFFF_FF00) | 32'd33;
      5: return ({$urandom} & 32'hFFFF_FF00) | 32'd64;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #1;
    n_cmp++;
    if (out_valid !== 1'b0) begin
      n_bad++; $display("FAIL R10 reset out_valid act=%b exp=0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    n_cmp++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++; $display("FAIL R10 after reset act=%b%b exp=01", out_valid, in_ready);
    end
    // directed corners: R1 R2 R3
    send(2'b00, 2'b00, 5'd0,  0, 32'h8000_0001, 0, 0, 1'b1);
    send(2'b00, 2'b00, 5'd1,  0, 32'h8000_0001, 0, 0, 1'b0);
    send(2'b00, 2'b00, 5'd31, 0, 32'h0000_0003, 0, 0, 1'b0);
    send(2'b00, 2'b01, 5'd0,  0, 32'h8000_0000, 0, 0, 1'b0);
    send(2'b00, 2'b10, 5'd0,  0, 32'h8000_0000, 0, 0, 1'b0);
    send(2'b00, 2'b10, 5'd4,  0, 32'hF000_0018, 0, 0, 1'b0);
    send(2'b00, 2'b11, 5'd0,  0, 32'h0000_0001, 0, 0, 1'b1);
    send(2'b00, 2'b11, 5'd8,  0, 32'h0000_0080, 0, 0, 1'b0);
    // R4 R5 R6 R7
    send(2'b01, 2'b00, 5'd3, 32'hFFFF_FF00, 32'h1234_5678, 0, 0, 1'b1);
    send(2'b01, 2'b00, 5'd0, 32'd32,  32'h0000_0001, 0, 0, 1'b0);
    send(2'b01, 2'b01, 5'd0, 32'd32,  32'h8000_0000, 0, 0, 1'b0);
    send(2'b01, 2'b00, 5'd0, 32'd33,  32'hFFFF_FFFF, 0, 0, 1'b1);
    send(2'b01, 2'b01, 5'd0, 32'd200, 32'hFFFF_FFFF, 0, 0, 1'b1);
    send(2'b01, 2'b10, 5'd0, 32'd255, 32'h8000_0000, 0, 0, 1'b0);
    send(2'b01, 2'b11, 5'd0, 32'd64,  32'h8000_0000, 0, 0, 1'b0);
    send(2'b01, 2'b11, 5'd0, 32'd36,  32'h0000_0010, 0, 0, 1'b0);
    // R8 R9
    send(2'b10, 2'b00, 5'd0, 0, 0, 8'hFF, 4'd0, 1'b1);
    send(2'b10, 2'b00, 5'd0, 0, 0, 8'h81, 4'd1, 1'b0);
    send(2'b10, 2'b00, 5'd0, 0, 0, 8'h03, 4'd15, 1'b0);
    send(2'b11, 2'b00, 5'd0, 0, 0, 8'hA5, 4'd7, 1'b1);
    // random traffic with back-pressure (R10 stalls)
    stall_on = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      send(2'($urandom), 2'($urandom), 5'($urandom), pick_rs(), $urandom,
           8'($urandom), 4'($urandom), 1'($urandom));
    end
    @(negedge clk);
    in_valid = 1'b0;
    stall_on = 1'b0;
    repeat (6) @(negedge clk);
    #2;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule